// File: doc/BRIEF.md
# Secure-Instruction Ordering Scoreboard

This block sits between decode and issue in an out-of-order core and enforces the order of a short chain of dependent security operations. First a pad is generated. An optional shift of that pad may follow. Last comes a secure load or secure store that uses the pad. The instructions of a chain need not be adjacent. Decode hands in one token per cycle, made of a class code and a flag marking it as issued under an unresolved branch. The block places the token in a free entry and returns that entry's index as its tag. For every entry it drives an issue-ready bit. That bit is held low while an older, still-incomplete member of an earlier chain step remains. The execution units return completion pulses, one bit per tag. A completion frees its entry.

Pad results produced under speculation are kept in a shadow register. They replace the live pipeline pad only when the guarding branch is confirmed. A mispredict discards every speculative entry and the shadow pad in one cycle. Setup and teardown tokens never become ready while speculative.

Top module: `sec_order_sb`

## Requirements
- R1: After reset no entry is valid, `issue_ready` is all zero, `alloc_ready` is 1, `alloc_tag` is 0 and `live_pad` is 0.
- R2: An accepted token takes the lowest-numbered free entry, and that index is shown on `alloc_tag`. When all 8 entries are occupied, `alloc_ready` is 0 and any offered token is dropped.
- R3: A shift token (class 1) is not ready while an older valid pad-generate token (class 0) exists.
- R4: A secure load (class 2) or secure store (class 3) is not ready while an older valid class 0 or class 1 token exists. With no shift present, it becomes ready the cycle after the most recent older generate completes.
- R5: A pad-generate token is ready as soon as it is allocated. Tokens allocated later never block older ones.
- R6: Several bits of `done_vec` in one cycle each free their own entry.
- R7: A setup/teardown token (class 4) allocated with `alloc_spec`=1 is not ready until `branch_ok`. With `alloc_spec`=0 it is ready at once.
- R8: A pad write (`pad_we`) tagged with a non-speculative valid entry updates `live_pad` on the next cycle.
- R9: A pad write tagged with a speculative entry leaves `live_pad` unchanged until `branch_ok`, which then loads that pad.
- R10: `branch_bad` removes every speculative entry and the shadow pad in one cycle. `live_pad` and the non-speculative entries are untouched. A later `branch_ok` then does not change `live_pad`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Decode offers a token |
| alloc_class | input | 3 | 0 generate, 1 shift, 2 secure load, 3 secure store, 4 setup/teardown |
| alloc_spec | input | 1 | Token lies behind an unresolved branch |
| alloc_ready | output | 1 | A free entry exists |
| alloc_tag | output | 3 | Entry index the offered token would take |
| done_vec | input | 8 | Completion pulse per tag |
| pad_we | input | 1 | Pad result valid |
| pad_tag | input | 3 | Tag of the token that produced the pad |
| pad_data | input | 32 | Pad value |
| branch_ok | input | 1 | Guarding branch confirmed |
| branch_bad | input | 1 | Guarding branch mispredicted (wins over branch_ok) |
| issue_ready | output | 8 | Per-entry eligibility to issue |
| live_pad | output | 32 | Committed pipeline pad |

## Verification
A wrong age relation or a stale priority code shows up on `issue_ready` in the cycle after the offending allocation or completion. The result is either a secure access released too early or an entry that never becomes ready. A lost shadow pad or a leaked speculative write shows up on `live_pad` one cycle after the branch outcome or the pad write. A slot that is not freed or not squashed shows up on `alloc_tag` and `alloc_ready` at the next allocation.

// File: rtl/sec_order_sb.sv
module sec_order_sb #(
  parameter int N  = 8,
  parameter int PW = 32,
  localparam int TW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  input  logic [2:0]    alloc_class,
  input  logic          alloc_spec,
  output logic          alloc_ready,
  output logic [TW-1:0] alloc_tag,
  input  logic [N-1:0]  done_vec,
  input  logic          pad_we,
  input  logic [TW-1:0] pad_tag,
  input  logic [PW-1:0] pad_data,
  input  logic          branch_ok,
  input  logic          branch_bad,
  output logic [N-1:0]  issue_ready,
  output logic [PW-1:0] live_pad
);

  function automatic logic [1:0] rank(input logic [2:0] c);
    case (c)
      3'd0:    return 2'd3;
      3'd1:    return 2'd2;
      3'd2,
      3'd3:    return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  logic [N-1:0]  valid, spec, fire_oh;
  logic [1:0]    prio  [N];
  logic [N-1:0]  older [N];
  logic [PW-1:0] shadow;
  logic          shadow_v;

  wire resolve = branch_ok | branch_bad;
  wire pad_hit = pad_we & valid[pad_tag];
  wire wr_spec = pad_hit & spec[pad_tag];
  wire wr_live = pad_hit & ~spec[pad_tag];

  assign alloc_ready = ~&valid;
  assign fire_oh = (alloc_valid & alloc_ready) ? (N'(1) << alloc_tag) : '0;

  always_comb begin
    alloc_tag = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!valid[i]) alloc_tag = TW'(i);
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic blk;
      blk = 1'b0;
      for (int j = 0; j < N; j++)
        if (older[i][j] && valid[j] && prio[i] != 2'd0 && prio[j] > prio[i]) blk = 1'b1;
      issue_ready[i] = valid[i] & ~blk & ~(prio[i] == 2'd0 && spec[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid    <= '0;
      spec     <= '0;
      shadow   <= '0;
      shadow_v <= 1'b0;
      live_pad <= '0;
      for (int i = 0; i < N; i++) begin
        prio[i]  <= '0;
        older[i] <= '0;
      end
    end else begin
      valid <= (valid & ~done_vec & ~(branch_bad ? spec : '0)) | fire_oh;
      spec  <= (resolve ? '0 : spec) | (alloc_spec ? fire_oh : '0);
      for (int i = 0; i < N; i++) begin
        older[i] <= older[i] & ~fire_oh;
        if (fire_oh[i]) begin
          older[i] <= valid;
          prio[i]  <= rank(alloc_class);
        end
      end
      if (resolve)
        shadow_v <= 1'b0;
      else if (wr_spec) begin
        shadow_v <= 1'b1;
        shadow   <= pad_data;
      end
      if (branch_ok && !branch_bad && wr_spec)
        live_pad <= pad_data;
      else if (branch_ok && !branch_bad && shadow_v)
        live_pad <= shadow;
      else if (wr_live)
        live_pad <= pad_data;
    end
  end

endmodule

// File: rtl/sec_order_sb_chk.sv
module sec_order_sb_chk #(
  parameter int N  = 8,
  parameter int PW = 32,
  localparam int TW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alloc_valid,
  input logic          alloc_ready,
  input logic [N-1:0]  done_vec,
  input logic          pad_we,
  input logic [TW-1:0] pad_tag,
  input logic [PW-1:0] pad_data,
  input logic          branch_ok,
  input logic          branch_bad,
  input logic [N-1:0]  issue_ready,
  input logic [PW-1:0] live_pad,
  input logic [N-1:0]  valid,
  input logic [N-1:0]  spec,
  input logic [1:0]    prio [N]
);

  logic [N-1:0] ctrl_mask;
  always_comb
    for (int i = 0; i < N; i++) ctrl_mask[i] = (prio[i] == 2'd0);

  // R2
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_ready && done_vec == '0 && !branch_bad) |=> valid == $past(valid));

  // R6
  done_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_vec & valid) != '0 |=> (valid & $past(done_vec & valid)) == '0);

  // R7
  ctrl_nonspec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_ready & spec & ctrl_mask) == '0);

  // R8
  live_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_we && valid[pad_tag] && !spec[pad_tag] && !branch_ok) |=> live_pad == $past(pad_data));

  // R10
  squash_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    branch_bad |=> (valid & $past(spec & ~done_vec)) == '0);

  // R10
  squash_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (branch_bad && !pad_we) |=> $stable(live_pad));

endmodule

bind sec_order_sb sec_order_sb_chk #(.N(N), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .done_vec(done_vec), .pad_we(pad_we), .pad_tag(pad_tag), .pad_data(pad_data),
  .branch_ok(branch_ok), .branch_bad(branch_bad), .issue_ready(issue_ready),
  .live_pad(live_pad), .valid(valid), .spec(spec), .prio(prio)
);

// File: tb/sec_order_sb_test.sv
module sec_order_sb_test;
  logic        clk = 0, rst_n = 0;
  logic        alloc_valid = 0, alloc_spec = 0, pad_we = 0, branch_ok = 0, branch_bad = 0;
  logic [2:0]  alloc_class = 0, pad_tag = 0;
  logic [7:0]  done_vec = 0;
  logic [31:0] pad_data = 0;
  logic        alloc_ready;
  logic [2:0]  alloc_tag;
  logic [7:0]  issue_ready;
  logic [31:0] live_pad;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  sec_order_sb uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step; @(posedge clk); #1; endtask

  task automatic alloc(input logic [2:0] c, input logic s);
    alloc_valid = 1; alloc_class = c; alloc_spec = s; step(); alloc_valid = 0; alloc_spec = 0;
  endtask
  task automatic done(input logic [7:0] m); done_vec = m; step(); done_vec = 0; endtask
  task automatic pad(input logic [2:0] t, input logic [31:0] d);
    pad_we = 1; pad_tag = t; pad_data = d; step(); pad_we = 0;
  endtask
  task automatic confirm; branch_ok = 1; step(); branch_ok = 0; endtask
  task automatic squash; branch_bad = 1; step(); branch_bad = 0; endtask

  task automatic t_reset;
    chk("R1 alloc_ready", alloc_ready, 1);
    chk("R1 issue_ready", issue_ready, 0);
    chk("R1 alloc_tag", alloc_tag, 0);
    chk("R1 live_pad", live_pad, 0);
  endtask

  task automatic t_chain;
    alloc(0, 0); alloc(1, 0); alloc(2, 0);
    chk("R3 R4 R5 chain blocked", issue_ready, 8'b001);
    done(8'b001);
    chk("R3 R4 shift free load held", issue_ready, 8'b010);
    done(8'b010);
    chk("R4 load free", issue_ready, 8'b100);
    done(8'b100);
    chk("R6 empty", issue_ready, 0);
  endtask

  task automatic t_noshift;
    alloc(0, 0); alloc(3, 0);
    chk("R4 store waits on seed", issue_ready, 8'b01);
    done(8'b01);
    chk("R4 store direct after seed", issue_ready, 8'b10);
    alloc(0, 0);
    chk("R2 lowest free tag reused", alloc_tag, 2);
    chk("R5 younger seed no block", issue_ready, 8'b11);
    done(8'b11);
    chk("R6 two done one cycle", issue_ready, 0);
    chk("R6 tag back to 0", alloc_tag, 0);
  endtask

  task automatic t_full;
    for (int i = 0; i < 8; i++) alloc(0, 0);
    chk("R2 full not ready", alloc_ready, 0);
    alloc(1, 0);
    chk("R2 token dropped when full", issue_ready, 8'hff);
    done(8'hff);
    chk("R6 all freed", alloc_ready, 1);
    chk("R6 none ready", issue_ready, 0);
  endtask

  task automatic t_ctrl;
    alloc(4, 1);
    chk("R7 spec ctrl held", issue_ready, 0);
    confirm();
    chk("R7 ctrl after confirm", issue_ready, 1);
    done(1);
    alloc(4, 0);
    chk("R7 nonspec ctrl ready", issue_ready, 1);
    done(1);
  endtask

  task automatic t_pad;
    alloc(0, 0);
    pad(0, 32'hA5A5_0001);
    chk("R8 live pad written", live_pad, 32'hA5A5_0001);
    done(1);
    alloc(0, 1);
    pad(0, 32'h1111_2222);
    chk("R9 spec pad held", live_pad, 32'hA5A5_0001);
    confirm();
    chk("R9 pad committed", live_pad, 32'h1111_2222);
    done(1);
  endtask

  task automatic t_squash;
    alloc(0, 0); alloc(0, 1); alloc(1, 1);
    pad(1, 32'h7777_7777);
    squash();
    chk("R10 only nonspec left", issue_ready, 8'b001);
    chk("R10 live kept", live_pad, 32'h1111_2222);
    chk("R10 freed slot", alloc_tag, 1);
    confirm();
    chk("R10 shadow dropped", live_pad, 32'h1111_2222);
    done(1);
    chk("R10 empty", issue_ready, 0);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(); step(); rst_n = 1; step();
    t_reset(); t_chain(); t_noshift(); t_full(); t_ctrl(); t_pad(); t_squash();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule